// File: doc/BRIEF.md
# Command-Driven SPI Master Engine

This block is an SPI master run by opcodes. Software first sets up the word length, the transmit and receive word counts, the chip-select line to use and the clock divider. It then writes one command word. The engine carries out one of several jobs: it shifts words out, shifts words in, does both at once, drives a chip-select line low or high on its own, or runs the serial clock with no data. Outgoing words come from a byte-wide valid/ready stream into a small internal FIFO. Incoming words leave on a byte-wide valid/ready stream, and the engine holds each word until the stream accepts it.

The bus runs in SPI mode 0. The clock idles low and the most significant bit goes first. MOSI changes only after a falling clock edge, and MISO is captured on the rising edge. A keep-selected flag in the command leaves chip select low after the transfer ends, so that several commands can form one frame. Three outputs show the engine's state: busy, a sticky command-done flag, and a flag that reports when the transmit FIFO level is at or below a threshold.

Top module: `spi_cmd_engine`

## Requirements
- R1: The register write port uses these addresses: 0 command, 1 word-length field, 2 transmit count, 3 receive count, 4 chip-select index, 5 divider, 6 status clear, 7 FIFO threshold. After reset the word-length field is 4, the divider is 1, the threshold is 1, and both counts and the index are 0. After reset every `cs_n_o` line is high, `sclk_o` is low, `busy_o` and `done_o` are low, and `tx_wm_o` is high.
- R2: A command word holds the opcode in bits [11:8] and parameters in bits [7:0]. Opcodes 1, 2 and 3 start a transfer. During a transfer SCLK idles low, MOSI changes only while SCLK is low, MISO is sampled as SCLK rises, and each word goes most significant bit first.
- R3: Bits per word equal the word-length field plus 4, capped at DATA_W (8). A word uses the low bits of a stream byte, and received words are right-aligned with the upper bits zero.
- R4: Opcode 1 (transmit only) sends the transmit-count number of words taken from the FIFO and produces no receive words. Opcode 2 (receive only) receives the receive-count number of words, holds MOSI low, and leaves the FIFO untouched.
- R5: Opcode 3 (full duplex) transfers the smaller of the two counts, sending and receiving one word per word slot.
- R6: A transfer command with bit 2 set leaves its chip-select line low after the transfer. Without bit 2 the line goes high when the transfer ends.
- R7: Opcode 8 drives the indexed chip-select line low and opcode 9 releases all lines. Each of them sets `done_o` on the cycle after the write.
- R8: A command acts only on the `cs_n_o` line named by the chip-select index. At most one line is ever low.
- R9: Opcode 10 runs SCLK for the transmit-count number of words. It holds MOSI low, does not change chip select, and does not pop the FIFO.
- R10: Each SCLK half period lasts the divider value in clock cycles, and a divider of 0 acts as 1.
- R11: `busy_o` is high during a transfer. Any command written while busy is ignored, and chip select does not change during the transfer.
- R12: `done_o` rises when a command completes and stays high until a write to address 6 with bit 0 set. A transfer whose count is 0 completes at once with no clock and no chip-select change.
- R13: `tx_wm_o` is high whenever the transmit FIFO level is at or below the threshold register.
- R14: A received word stays on `rx_data_o` with `rx_valid_o` high until `rx_ready_i` accepts it. The engine does not start the next word while a received word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | LEN_W (24) | Register write data |
| tx_data_i | input | DATA_W (8) | Transmit stream data |
| tx_valid_i | input | 1 | Transmit stream valid |
| tx_ready_o | output | 1 | Transmit FIFO has room |
| rx_data_o | output | DATA_W (8) | Received word |
| rx_valid_o | output | 1 | Received word waiting |
| rx_ready_i | input | 1 | Receive stream ready |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS (2) | Chip-select lines, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky command-complete flag |
| tx_wm_o | output | 1 | FIFO level at or below threshold |

## Verification
The bench sweeps every word length from 4 to 8 bits, plus one value above the cap, across the three data opcodes and counts of 1 to 3. In full duplex the two counts differ, so an engine that used the larger count would show extra clock edges, and one that ignored the cap would shift nine bits per word. Edge counts at the pins catch an off-by-one in the bit or word counters. A model slave catches a reversed bit order or a misplaced MISO sample. A divider of zero would hang an engine that counts down to it. A stop-deassert command sent mid-transfer would drop chip select early if busy gating were missing. A stalled receive stream must freeze SCLK after exactly one word, and the clock-only command must leave the FIFO level and chip select alone.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [3:0] OP_TX     = 4'd1;
  localparam logic [3:0] OP_RX     = 4'd2;
  localparam logic [3:0] OP_FD     = 4'd3;
  localparam logic [3:0] OP_CS_ON  = 4'd8;
  localparam logic [3:0] OP_CS_OFF = 4'd9;
  localparam logic [3:0] OP_CLK    = 4'd10;

  localparam logic [2:0] A_CMD   = 3'd0;
  localparam logic [2:0] A_WLEN  = 3'd1;
  localparam logic [2:0] A_TXLEN = 3'd2;
  localparam logic [2:0] A_RXLEN = 3'd3;
  localparam logic [2:0] A_CSSEL = 3'd4;
  localparam logic [2:0] A_DIV   = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_TXWM  = 3'd7;

  localparam int OP_LSB   = 8;
  localparam int FRAG_BIT = 2;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_LO, S_HI} st_e;
endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = cnt_q == LW'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, lim;

  // zero divider behaves as one
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_CS     = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 24,
  parameter int DIV_W      = 8,
  parameter int WL_W       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [LEN_W-1:0]  wr_data_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tx_wm_o
);
  localparam int BC_W  = $clog2(DATA_W);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [WL_W-1:0]   wlen_q;
  logic [LEN_W-1:0]  txlen_q, rxlen_q, words_q, len_w;
  logic [CS_W-1:0]   cssel_q, cs_idx_q;
  logic [DIV_W-1:0]  div_q;
  logic [LVL_W-1:0]  wm_q, fifo_lvl;
  st_e               st_q;
  logic              do_tx_q, do_rx_q, drive_cs_q, frag_q, cs_act_q;
  logic              sclk_q, done_q, rxv_q;
  logic [BC_W:0]     bits_q, wbits;
  logic [BC_W-1:0]   bitc_q;
  logic [DATA_W-1:0] sh_q, rxsh_q, rx_q, wmask, fifo_dout;
  logic [WL_W:0]     wb_full;
  logic              fifo_full, fifo_empty, tick, ld_ok, accept, is_xfer;
  logic [3:0]        op_w;

  assign wb_full = {1'b0, wlen_q} + (WL_W+1)'(4);
  assign wbits   = (wb_full > (WL_W+1)'(DATA_W)) ? (BC_W+1)'(DATA_W) : wb_full[BC_W:0];
  assign wmask   = (DATA_W'(1) << bits_q) - 1'b1;

  assign op_w    = wr_data_i[OP_LSB+3:OP_LSB];
  assign accept  = wr_en_i && (wr_addr_i == A_CMD) && (st_q == S_IDLE);
  assign is_xfer = (op_w == OP_TX) || (op_w == OP_RX) || (op_w == OP_FD) || (op_w == OP_CLK);

  always_comb begin
    case (op_w)
      OP_RX:   len_w = rxlen_q;
      OP_FD:   len_w = (txlen_q < rxlen_q) ? txlen_q : rxlen_q;
      default: len_w = txlen_q;
    endcase
  end

  assign ld_ok = (!do_tx_q || !fifo_empty) && (!do_rx_q || !rxv_q);

  spi_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .data_i  (tx_data_i),
    .pop_i   ((st_q == S_LOAD) && ld_ok && do_tx_q),
    .data_o  (fifo_dout),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .level_o (fifo_lvl)
  );

  spi_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   ((st_q == S_LO) || (st_q == S_HI)),
    .div_i  (div_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wlen_q <= WL_W'(4);   txlen_q <= '0;  rxlen_q <= '0;
      cssel_q <= '0;        div_q <= DIV_W'(1);  wm_q <= LVL_W'(1);
      st_q <= S_IDLE;       words_q <= '0;  bits_q <= '0;  bitc_q <= '0;
      do_tx_q <= 1'b0;      do_rx_q <= 1'b0; drive_cs_q <= 1'b0; frag_q <= 1'b0;
      cs_act_q <= 1'b0;     cs_idx_q <= '0;
      sh_q <= '0;           rxsh_q <= '0;   rx_q <= '0;
      sclk_q <= 1'b0;       done_q <= 1'b0; rxv_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          A_WLEN:  wlen_q  <= wr_data_i[WL_W-1:0];
          A_TXLEN: txlen_q <= wr_data_i;
          A_RXLEN: rxlen_q <= wr_data_i;
          A_CSSEL: cssel_q <= wr_data_i[CS_W-1:0];
          A_DIV:   div_q   <= wr_data_i[DIV_W-1:0];
          A_TXWM:  wm_q    <= wr_data_i[LVL_W-1:0];
          A_STAT:  if (wr_data_i[0]) done_q <= 1'b0;
          default: ;
        endcase
      end
      if (rxv_q && rx_ready_i) rxv_q <= 1'b0;

      case (st_q)
        S_IDLE: if (accept) begin
          if (op_w == OP_CS_ON) begin
            cs_act_q <= 1'b1;
            cs_idx_q <= cssel_q;
            done_q   <= 1'b1;
          end else if (op_w == OP_CS_OFF) begin
            cs_act_q <= 1'b0;
            done_q   <= 1'b1;
          end else if (is_xfer) begin
            if (len_w == '0) done_q <= 1'b1;
            else begin
              st_q       <= S_LOAD;
              words_q    <= len_w;
              bits_q     <= wbits;
              frag_q     <= wr_data_i[FRAG_BIT];
              do_tx_q    <= (op_w == OP_TX) || (op_w == OP_FD);
              do_rx_q    <= (op_w == OP_RX) || (op_w == OP_FD);
              drive_cs_q <= op_w != OP_CLK;
              if (op_w != OP_CLK) begin
                cs_act_q <= 1'b1;
                cs_idx_q <= cssel_q;
              end
            end
          end
        end
        S_LOAD: if (ld_ok) begin
          sh_q   <= do_tx_q ? fifo_dout : '0;
          bitc_q <= BC_W'(bits_q - 1'b1);
          st_q   <= S_LO;
        end
        S_LO: if (tick) begin
          sclk_q <= 1'b1;
          rxsh_q <= {rxsh_q[DATA_W-2:0], miso_i};
          st_q   <= S_HI;
        end
        S_HI: if (tick) begin
          sclk_q <= 1'b0;
          st_q   <= S_LO;
          if (bitc_q == '0) begin
            if (do_rx_q) begin
              rx_q  <= rxsh_q & wmask;
              rxv_q <= 1'b1;
            end
            words_q <= words_q - 1'b1;
            if (words_q == LEN_W'(1)) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
              if (drive_cs_q && !frag_q) cs_act_q <= 1'b0;
            end else begin
              st_q <= S_LOAD;
            end
          end else begin
            bitc_q <= bitc_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !(cs_act_q && (cs_idx_q == CS_W'(i)));
  end

  assign mosi_o     = ((st_q == S_LO) || (st_q == S_HI)) ? sh_q[bitc_q] : 1'b0;
  assign sclk_o     = sclk_q;
  assign busy_o     = st_q != S_IDLE;
  assign done_o     = done_q;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = rxv_q;
  assign tx_ready_o = !fifo_full;
  assign tx_wm_o    = fifo_lvl <= wm_q;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              cs_cmd_i,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_o
);
  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  a_r2_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  a_r8_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  a_r11_cs_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cs_n_o));

  a_r12_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);

  a_r7_cs_cmd_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_cmd_i && !busy_o |=> done_o && !busy_o);

  a_r14_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (wr_en_i && (wr_addr_i == 3'd6) && wr_data_i[0]),
  .cs_cmd_i   (wr_en_i && (wr_addr_i == 3'd0) &&
               ((wr_data_i[11:8] == 4'd8) || (wr_data_i[11:8] == 4'd9))),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_n_o     (cs_n_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .rx_data_o  (rx_data_o)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b1;
  logic        tx_ready, rx_valid, sclk, mosi, miso, busy, done, tx_wm;
  logic [7:0]  rx_data;
  logic [1:0]  cs_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int e = 0, bits_t = 8, rxn = 0, per = 0, last_rise = 0;
  logic [7:0] cap [16];
  logic [7:0] rxw [16];
  logic [1:0] cs_low = '0;

  always #2.5 clk = ~clk;

  spi_cmd_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n),
    .busy_o(busy), .done_o(done), .tx_wm_o(tx_wm)
  );

  function automatic logic [7:0] txb(int k, int b);
    return 8'((k * 53 + b * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] sw(int k);
    return 8'((k * 37 + 107) & 255);
  endfunction
  function automatic logic sbit(int ee, int b);
    logic [7:0] w;
    w = sw(ee / b);
    return w[b - 1 - (ee % b)];
  endfunction

  // model slave: next MISO bit presented after each rising edge
  assign miso = sbit(e, bits_t);

  always @(posedge sclk) begin
    if (e / bits_t < 16) cap[e / bits_t][bits_t - 1 - (e % bits_t)] = mosi;
    e++;
    per = cyc - last_rise;
    last_rise = cyc;
  end

  always @(posedge clk) begin
    cyc++;
    if (rx_valid && rx_ready) begin
      if (rxn < 16) rxw[rxn] = rx_data;
      rxn++;
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) if (busy) cs_low = cs_low | ~cs_n;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 24'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!done) chk("R12 done timeout", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic arm(int b);
    e = 0; rxn = 0; cs_low = '0; bits_t = b;
    for (int i = 0; i < 16; i++) begin cap[i] = '0; rxw[i] = '0; end
  endtask

  task automatic xfer(int op, int frag, int ntx, int nrx, int wl, bit do_push);
    int b, len;
    logic [7:0] m;
    b = (wl + 4 > 8) ? 8 : wl + 4;
    m = 8'((1 << b) - 1);
    len = (op == 2) ? nrx : (op == 3) ? ((ntx < nrx) ? ntx : nrx) : ntx;
    wr(3'd1, wl); wr(3'd2, ntx); wr(3'd3, nrx); wr(3'd6, 1);
    arm(b);
    if (do_push && (op == 1 || op == 3))
      for (int k = 0; k < len; k++) push(txb(k, 8));
    wr(3'd0, (op << 8) | (frag << 2));
    wait_done();
    chk("R3 R5 sclk edges", 32'(e), 32'(len * b));
    for (int k = 0; k < len; k++) begin
      if (op == 1 || op == 3) chk("R2 R3 mosi word", 32'(cap[k]), 32'(txb(k, 8) & m));
      else                    chk("R4 R9 mosi low", 32'(cap[k]), 0);
    end
    if (op == 2 || op == 3) begin
      chk("R5 rx count", 32'(rxn), 32'(len));
      for (int k = 0; k < len; k++) chk("R2 R3 rx word", 32'(rxw[k]), 32'(sw(k) & m));
    end else begin
      chk("R4 no rx words", 32'(rxn), 0);
    end
    if (op == 10) chk("R9 cs untouched", 32'(cs_low), 0);
    else          chk("R6 cs after xfer", 32'(cs_n[0]), frag ? 0 : 1);
    if (frag) begin
      wr(3'd6, 1);
      wr(3'd0, 9 << 8);
      @(negedge clk);
      chk("R7 deassert cs", 32'(cs_n), 3);
      chk("R7 deassert done", 32'(done), 1);
    end
    wr(3'd6, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 3);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 tx_wm", 32'(tx_wm), 1);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 tx_ready", 32'(tx_ready), 1);

    // sweep: word lengths, data opcodes, counts
    for (int wl = 0; wl <= 5; wl++)
      for (int op = 1; op <= 3; op++)
        for (int n = 1; n <= 3; n++)
          xfer(op, (n == 2) ? 1 : 0, (op == 3 && n == 3) ? n + 1 : n,
               (op == 3 && n != 3) ? n + 1 : n, wl, 1'b1);

    // R13 watermark threshold
    push(txb(0, 8));
    @(negedge clk);
    chk("R13 level1", 32'(tx_wm), 1);
    push(txb(1, 8));
    @(negedge clk);
    chk("R13 level2", 32'(tx_wm), 0);
    wr(3'd7, 2);
    @(negedge clk);
    chk("R13 thresh2", 32'(tx_wm), 1);
    wr(3'd7, 1);
    @(negedge clk);
    chk("R13 thresh1", 32'(tx_wm), 0);

    // R9 clock only leaves FIFO alone
    xfer(10, 0, 2, 0, 1, 1'b0);
    chk("R9 fifo kept", 32'(tx_wm), 0);
    // drain the two bytes via transmit only
    xfer(1, 0, 2, 0, 4, 1'b0);
    chk("R13 drained", 32'(tx_wm), 1);

    // R10 divider
    for (int d = 0; d <= 3; d++) begin
      wr(3'd5, d);
      xfer(2, 0, 0, 1, 4, 1'b0);
      chk("R10 sclk period", 32'(per), 32'(2 * ((d == 0) ? 1 : d)));
    end
    wr(3'd5, 1);

    // R8 chip select index
    wr(3'd4, 1);
    wr(3'd1, 4); wr(3'd2, 1); wr(3'd6, 1);
    arm(8);
    push(8'h3c);
    wr(3'd0, 1 << 8);
    wait_done();
    chk("R8 only cs1 low", 32'(cs_low), 2);
    chk("R8 word", 32'(cap[0]), 32'h3c);
    wr(3'd4, 0); wr(3'd6, 1);

    // R7 standalone chip select commands
    wr(3'd0, 8 << 8);
    chk("R7 assert done", 32'(done), 1);
    chk("R7 assert cs", 32'(cs_n), 2);
    chk("R7 not busy", 32'(busy), 0);
    wr(3'd6, 1);
    wr(3'd0, 9 << 8);
    chk("R7 release cs", 32'(cs_n), 3);
    chk("R7 release done", 32'(done), 1);
    wr(3'd6, 1);

    // R11 commands ignored while busy
    wr(3'd5, 3); wr(3'd3, 3);
    arm(8);
    wr(3'd0, 2 << 8);
    repeat (4) @(negedge clk);
    chk("R11 busy", 32'(busy), 1);
    wr(3'd0, 9 << 8);
    wr(3'd0, 3 << 8);
    chk("R11 cs held", 32'(cs_n[0]), 0);
    chk("R11 no early done", 32'(done), 0);
    wait_done();
    chk("R11 edges", 32'(e), 24);
    chk("R11 rx words", 32'(rxn), 3);
    chk("R11 cs released", 32'(cs_n), 3);
    wr(3'd5, 1); wr(3'd6, 1);

    // R12 zero count and write-one-to-clear
    wr(3'd2, 0);
    arm(8);
    wr(3'd0, 1 << 8);
    @(negedge clk);
    chk("R12 zero len done", 32'(done), 1);
    chk("R12 zero len idle", 32'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R12 zero len edges", 32'(e), 0);
    chk("R12 zero len cs", 32'(cs_low), 0);
    wr(3'd6, 0);
    chk("R12 write0 keeps", 32'(done), 1);
    wr(3'd6, 1);
    chk("R12 w1c clears", 32'(done), 0);

    // R14 receive backpressure
    rx_ready = 1'b0;
    wr(3'd3, 2);
    arm(8);
    wr(3'd0, 2 << 8);
    repeat (100) @(negedge clk);
    chk("R14 stalled edges", 32'(e), 8);
    chk("R14 valid held", 32'(rx_valid), 1);
    chk("R14 data held", 32'(rx_data), 32'(sw(0)));
    chk("R14 still busy", 32'(busy), 1);
    rx_ready = 1'b1;
    wait_done();
    chk("R14 final edges", 32'(e), 16);
    chk("R14 rx count", 32'(rxn), 2);
    chk("R14 word1", 32'(rxw[1]), 32'(sw(1)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule